// File: doc/BRIEF.md
# Pipelined Unsigned Multiply-Accumulate Unit

This block multiplies two unsigned operands on every clock cycle and folds each product into a running sum. The work is spread across three register stages. The first stage captures both operands. The second stage holds their full-width product. The third stage is the accumulator, and it adds the product registered one cycle earlier to its own value. The accumulator value is the only output.

Operand width and accumulator width are parameters, with defaults of 6 and 12 bits. When the sum passes the top of the accumulator range it wraps around, because no saturation is applied. A synchronous reset and a synchronous clear input both zero every stage on the next clock edge. After a clear, accumulation starts again from zero with the normal latency.

Top module: `umac_pipe`

## Requirements
- R1: After a clock edge with `rst_i` high, `acc_o`, the operand stage and the product stage all hold zero.
- R2: An operand pair presented before clock edge k first shows up in `acc_o` after edge k+2, that is three edges after it is presented. `acc_o` does not change before that edge.
- R3: With no clear active, every pair presented on consecutive cycles adds its product to `acc_o`, so `acc_o` is the sum of all products that have passed through the pipeline.
- R4: The sum wraps modulo 2^ACCW (4096 by default). With no clear active, 63*63 added twice gives 3842 and added three times gives 3715.
- R5: A clock edge with `clr_i` high sets `acc_o` to zero. It also discards the pairs held in the operand and product stages and the pair presented on that edge, so none of them ever reach `acc_o`.
- R6: After a clear, a pair presented on the next cycle with `clr_i` low accumulates from zero with the latency of R2.
- R7: The largest operands (63 and 63) produce the full product 3969 without loss.
- R8: A pair in which either operand is zero leaves `acc_o` unchanged when it reaches the accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| clr_i | input | 1 | Synchronous clear of all stages, active high |
| a_i | input | OPW | First unsigned operand |
| b_i | input | OPW | Second unsigned operand |
| acc_o | output | ACCW | Running accumulated sum |

## Verification
A pair driven before edge k is in the operand stage after edge k and in the product stage after edge k+1. It reaches `acc_o` after edge k+2, so each scenario counts exactly three clock edges from presentation to the expected sum. A clear takes effect on the single edge that samples it, and the check comes right after that edge. Later checks confirm that the pairs flushed by the clear never appear. The bench changes inputs and reads `acc_o` on the falling clock edge, so every comparison falls half a period after the edge that updated the output.

// File: rtl/umac_pkg.sv
package umac_pkg;
  localparam int unsigned UMAC_DEF_OPW  = 6;
  localparam int unsigned UMAC_DEF_ACCW = 12;
  localparam int unsigned UMAC_NUM_OPND = 2;
endpackage

// File: rtl/umac_reg.sv
module umac_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         zero_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i) begin
    if (zero_i) q_o <= '0;
    else        q_o <= d_i;
  end
endmodule

// File: rtl/umac_mult_stage.sv
module umac_mult_stage #(
  parameter int unsigned OPW = 6,
  localparam int unsigned PRW = 2 * OPW
) (
  input  logic           clk_i,
  input  logic           zero_i,
  input  logic [OPW-1:0] x_i,
  input  logic [OPW-1:0] y_i,
  output logic [PRW-1:0] prod_o
);
  function automatic logic [PRW-1:0] mul_full(input logic [OPW-1:0] x, input logic [OPW-1:0] y);
    logic [PRW-1:0] xw, yw;
    xw = PRW'(x);
    yw = PRW'(y);
    return xw * yw;
  endfunction

  logic [PRW-1:0] prod_d;
  assign prod_d = mul_full(x_i, y_i);

  umac_reg #(.W(PRW)) prod_reg_i (
    .clk_i (clk_i),
    .zero_i(zero_i),
    .d_i   (prod_d),
    .q_o   (prod_o)
  );
endmodule

// File: rtl/umac_acc_stage.sv
module umac_acc_stage #(
  parameter int unsigned PRW  = 12,
  parameter int unsigned ACCW = 12
) (
  input  logic            clk_i,
  input  logic            zero_i,
  input  logic [PRW-1:0]  prod_i,
  output logic [ACCW-1:0] acc_o,
  output logic [ACCW-1:0] acc_next_o
);
  function automatic logic [ACCW-1:0] fit_acc(input logic [PRW-1:0] p);
    return ACCW'(p);
  endfunction

  function automatic logic [ACCW-1:0] wrap_add(input logic [ACCW-1:0] s, input logic [ACCW-1:0] t);
    return s + t;
  endfunction

  assign acc_next_o = wrap_add(acc_o, fit_acc(prod_i));

  umac_reg #(.W(ACCW)) acc_reg_i (
    .clk_i (clk_i),
    .zero_i(zero_i),
    .d_i   (acc_next_o),
    .q_o   (acc_o)
  );
endmodule

// File: rtl/umac_pipe.sv
module umac_pipe
  import umac_pkg::*;
#(
  parameter int unsigned OPW  = UMAC_DEF_OPW,
  parameter int unsigned ACCW = UMAC_DEF_ACCW,
  localparam int unsigned PRW = 2 * OPW
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            clr_i,
  input  logic [OPW-1:0]  a_i,
  input  logic [OPW-1:0]  b_i,
  output logic [ACCW-1:0] acc_o
);
  logic                              flush;
  logic [UMAC_NUM_OPND-1:0][OPW-1:0] opnd_d;
  logic [UMAC_NUM_OPND-1:0][OPW-1:0] opnd_q;
  logic [PRW-1:0]                    prod_q;
  logic [ACCW-1:0]                   acc_next;

  assign flush     = rst_i | clr_i;
  assign opnd_d[0] = a_i;
  assign opnd_d[1] = b_i;

  for (genvar g = 0; g < UMAC_NUM_OPND; g++) begin : g_opnd
    umac_reg #(.W(OPW)) opnd_reg_i (
      .clk_i (clk_i),
      .zero_i(flush),
      .d_i   (opnd_d[g]),
      .q_o   (opnd_q[g])
    );
  end

  umac_mult_stage #(.OPW(OPW)) mult_i (
    .clk_i (clk_i),
    .zero_i(flush),
    .x_i   (opnd_q[0]),
    .y_i   (opnd_q[1]),
    .prod_o(prod_q)
  );

  umac_acc_stage #(.PRW(PRW), .ACCW(ACCW)) acc_i (
    .clk_i     (clk_i),
    .zero_i    (flush),
    .prod_i    (prod_q),
    .acc_o     (acc_o),
    .acc_next_o(acc_next)
  );
endmodule

// File: rtl/umac_pipe_chk.sv
module umac_pipe_chk #(
  parameter int unsigned OPW  = 6,
  parameter int unsigned ACCW = 12,
  localparam int unsigned PRW = 2 * OPW
) (
  input logic            clk_i,
  input logic            rst_i,
  input logic            clr_i,
  input logic [OPW-1:0]  a_i,
  input logic [OPW-1:0]  b_i,
  input logic [ACCW-1:0] acc_o,
  input logic [OPW-1:0]  opa_q,
  input logic [OPW-1:0]  opb_q,
  input logic [PRW-1:0]  prod_q
);
  function automatic logic [ACCW-1:0] term(input logic [OPW-1:0] x, input logic [OPW-1:0] y);
    logic [PRW-1:0] p;
    p = PRW'(x) * PRW'(y);
    return ACCW'(p);
  endfunction

  logic [1:0] quiet_cnt;
  logic       rst_seen_q;

  always_ff @(posedge clk_i) begin
    rst_seen_q <= rst_i;
    if (rst_i || clr_i)      quiet_cnt <= '0;
    else if (quiet_cnt != 3) quiet_cnt <= quiet_cnt + 2'd1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_seen_q) begin
      a_r1_reset_zero: assert (acc_o == '0 && opa_q == '0 && opb_q == '0 && prod_q == '0)
        else $error("a_r1_reset_zero");
    end
  end

  // R3, R4: wrapping sum of the pair presented three edges earlier
  a_r3_sum_window: assert property (@(posedge clk_i) disable iff (rst_i)
    (quiet_cnt == 2'd3) |-> acc_o == ACCW'($past(acc_o) + term($past(a_i, 3), $past(b_i, 3))));

  a_r5_clear_flush: assert property (@(posedge clk_i) disable iff (rst_i)
    clr_i |=> (acc_o == '0 && prod_q == '0 && opa_q == '0 && opb_q == '0));

  a_r8_zero_operand: assert property (@(posedge clk_i) disable iff (rst_i)
    ((quiet_cnt == 2'd3) && ($past(a_i, 3) == '0 || $past(b_i, 3) == '0)) |-> acc_o == $past(acc_o));
endmodule

bind umac_pipe umac_pipe_chk #(.OPW(OPW), .ACCW(ACCW)) chk_i (
  .clk_i (clk_i),
  .rst_i (rst_i),
  .clr_i (clr_i),
  .a_i   (a_i),
  .b_i   (b_i),
  .acc_o (acc_o),
  .opa_q (opnd_q[0]),
  .opb_q (opnd_q[1]),
  .prod_q(prod_q)
);

// File: tb/umac_pipe_tb_top.sv
module umac_pipe_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int OPW  = 6;
  localparam int ACCW = 12;
  localparam int MODV = 1 << ACCW;

  logic            clk = 1'b0;
  logic            rst_i = 1'b1;
  logic            clr_i = 1'b0;
  logic [OPW-1:0]  a_i = '0;
  logic [OPW-1:0]  b_i = '0;
  logic [ACCW-1:0] acc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  umac_pipe #(.OPW(OPW), .ACCW(ACCW)) dut_i (
    .clk_i(clk), .rst_i(rst_i), .clr_i(clr_i), .a_i(a_i), .b_i(b_i), .acc_o(acc_o)
  );

  task automatic tick(input int a, input int b, input bit clr);
    a_i   = OPW'(a);
    b_i   = OPW'(b);
    clr_i = clr;
    @(negedge clk);
  endtask

  task automatic expect_acc(input int exp, input string req);
    checks++;
    if (int'(acc_o) != exp) begin
      errors++;
      $display("FAIL %s acc_o=%0d expected=%0d", req, acc_o, exp);
    end
  endtask

  task automatic restart();
    tick(0, 0, 1'b1);
    tick(0, 0, 1'b0);
  endtask

  task automatic t_reset();
    rst_i = 1'b1;
    tick(9, 9, 1'b0);
    tick(9, 9, 1'b0);
    expect_acc(0, "R1 after reset");
    rst_i = 1'b0;
    tick(0, 0, 1'b0);
    tick(0, 0, 1'b0);
    expect_acc(0, "R1 no leakage of pairs held during reset");
  endtask

  task automatic t_latency();
    restart();
    tick(5, 7, 1'b0);
    expect_acc(0, "R2 after first edge");
    tick(0, 0, 1'b0);
    expect_acc(0, "R2 after second edge");
    tick(0, 0, 1'b0);
    expect_acc(35, "R2 after third edge");
  endtask

  task automatic t_stream();
    int sum = 0;
    restart();
    for (int i = 1; i <= 10; i++) begin
      tick(i, 2 * i + 1, 1'b0);
      if (i > 2) sum += (i - 2) * (2 * (i - 2) + 1);
    end
    expect_acc(sum % MODV, "R3 mid-stream sum");
    sum += 9 * 19;
    tick(0, 0, 1'b0);
    expect_acc(sum % MODV, "R3 stream sum step");
    sum += 10 * 21;
    tick(0, 0, 1'b0);
    expect_acc(sum % MODV, "R3 full stream sum");
  endtask

  task automatic t_max_and_wrap();
    restart();
    tick(63, 63, 1'b0);
    tick(63, 63, 1'b0);
    tick(63, 63, 1'b0);
    expect_acc(3969, "R7 full product");
    tick(0, 0, 1'b0);
    expect_acc((2 * 3969) % MODV, "R4 wrap after two");
    tick(0, 0, 1'b0);
    expect_acc((3 * 3969) % MODV, "R4 wrap after three");
  endtask

  task automatic t_zero_operand();
    restart();
    tick(20, 30, 1'b0);
    tick(0, 55, 1'b0);
    tick(41, 0, 1'b0);
    expect_acc(600, "R8 base value");
    tick(0, 0, 1'b0);
    expect_acc(600, "R8 zero a");
    tick(0, 0, 1'b0);
    expect_acc(600, "R8 zero b");
  endtask

  task automatic t_clear();
    restart();
    tick(10, 10, 1'b0);
    tick(0, 0, 1'b0);
    tick(9, 9, 1'b0);
    tick(8, 8, 1'b0);
    expect_acc(100, "R5 value before clear");
    tick(7, 7, 1'b1);
    expect_acc(0, "R5 clear edge");
    tick(0, 0, 1'b0);
    tick(0, 0, 1'b0);
    tick(0, 0, 1'b0);
    expect_acc(0, "R5 flushed pairs never arrive");
    tick(3, 4, 1'b0);
    tick(0, 0, 1'b0);
    expect_acc(0, "R6 not yet after clear");
    tick(0, 0, 1'b0);
    expect_acc(12, "R6 resumes after clear");
  endtask

  task automatic t_clear_back_to_back();
    restart();
    tick(6, 6, 1'b1);
    tick(2, 5, 1'b0);
    tick(1, 1, 1'b0);
    tick(0, 0, 1'b0);
    expect_acc(10, "R6 pair right after clear");
    tick(0, 0, 1'b0);
    expect_acc(11, "R6 second pair after clear");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_latency();
    t_stream();
    t_max_and_wrap();
    t_zero_operand();
    t_clear();
    t_clear_back_to_back();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule